// File: doc/BRIEF.md
# LIN Transceiver Power-Mode Controller

This block sequences a LIN bus node's transceiver and regulator through its four power modes: Pre-normal, Normal, Silent and Sleep. It watches the enable pin, the transmit data line, the sampled bus level and a local wake pin. From these inputs it decides the mode, gates the bus driver and termination, signals wake events on the receive line and drives an active-low reset output. Every time constant is a parameter counted in clock ticks, and the inputs are taken to be synchronous to the clock.

A host moves the node into Normal by raising the enable pin. Dropping the enable pin takes the node out of Normal. It goes to Sleep when the transmit line went dominant shortly before the enable fall and is still dominant. In every other case it goes to Silent, where the bus is still monitored. A long enough dominant bus period, or a falling edge on the local wake pin, brings the node back to Pre-normal. A separate guard cuts the bus driver when the transmit line stays dominant too long.

There is no data stream through this block. All of its pins are plain level-sensitive control and status pins, and none of them has a valid/ready handshake or back-pressure.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While `por_n` is low, `mode_o` reads 0 (Pre-normal) and `nres_o` is low. After `por_n` rises, `nres_o` goes high after exactly HOLD_TICKS rising clock edges.
- R2: In Pre-normal, a high sample of `en_i` moves the node to Normal (`mode_o`=1). In Normal, `tx_en_o` and `term_en_o` are high, and `bus_drv_o` follows `txd_i` (0 is dominant).
- R3: In Normal, a falling edge of `en_i` leads to Sleep (`mode_o`=3) when `txd_i` is low on that sample and has been low for at most SLEEP_WIN_TICKS consecutive samples, counting that one. In Sleep, `reg_on_o` and `nres_o` are low, and Sleep is entered from no mode other than Normal.
- R4: Any other falling edge of `en_i` in Normal leads to Silent (`mode_o`=2). In Silent, `reg_lowtol_o` is high, `tx_en_o` and `term_en_o` are low, and `rxd_o` follows `bus_i`.
- R5: A high sample of `en_i` in Silent moves the node straight to Normal.
- R6: In Silent or Sleep, after at least one recessive bus sample, WAKE_DOM_TICKS consecutive dominant samples of `bus_i` move the node to Pre-normal. A shorter dominant pulse, or a bus that has been dominant ever since the mode was entered, does not change the mode.
- R7: In Silent or Sleep, a falling edge on `wake_n_i` moves the node to Pre-normal at the edge where the low level is first sampled.
- R8: After a wake event, `rxd_o` is low until `en_i` is sampled high, which also moves the node to Normal. A wake from Sleep restarts the reset hold, so `nres_o` stays low for HOLD_TICKS edges. A wake from Silent leaves `nres_o` high.
- R9: When `txd_i` is low for TXD_TO_TICKS consecutive samples, `tx_en_o` drops and `bus_drv_o` stays recessive (1). This holds until a high sample of `txd_i` clears it.
- R10: In Normal, the wake pin and bus activity have no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up indication, active low, asynchronous |
| en_i | input | 1 | Mode enable from the host |
| txd_i | input | 1 | Transmit data, 0 = dominant |
| bus_i | input | 1 | Sampled bus level, 0 = dominant |
| wake_n_i | input | 1 | Local wake pin, falling-edge active |
| mode_o | output | 2 | 0 Pre-normal, 1 Normal, 2 Silent, 3 Sleep |
| reg_on_o | output | 1 | Regulator enabled |
| reg_lowtol_o | output | 1 | Regulator in low-tolerance operation |
| term_en_o | output | 1 | Bus termination enabled |
| tx_en_o | output | 1 | Bus driver enabled |
| bus_drv_o | output | 1 | Level driven onto the bus |
| rxd_o | output | 1 | Receive data or wake indication (low) |
| nres_o | output | 1 | Reset output, active low |

## Verification
The bench builds the controller with HOLD_TICKS=6, SLEEP_WIN_TICKS=4, WAKE_DOM_TICKS=5 and TXD_TO_TICKS=10. With these short windows, random lengths from 1 to a few samples past each limit reach both sides of every timer boundary in a few cycles. These include a TXD lead of exactly the window against one more sample, a dominant pulse one sample short of the filter time, and a TXD low time one sample under the time-out. Directed cases add a bus that is dominant from mode entry, wakes from both Silent and Sleep, and the reset hold restarted by a wake from Sleep.

// File: rtl/lin_mc_pkg.sv
package lin_mc_pkg;
  typedef enum logic [1:0] {
    MODE_PRE    = 2'd0,
    MODE_NORM   = 2'd1,
    MODE_SILENT = 2'd2,
    MODE_SLEEP  = 2'd3
  } lin_mode_e;
endpackage

// File: rtl/lin_wake_filter.sv
// Remote wake filter: arms on a recessive sample, then needs a run of
// dominant samples of the programmed length while the filter is active.
module lin_wake_filter #(
  parameter int DOM_TICKS = 1200
) (
  input  logic clk,
  input  logic por_n,
  input  logic active_i,
  input  logic bus_i,
  output logic wake_o
);
  localparam int CW = $clog2(DOM_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(DOM_TICKS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      armed_q <= 1'b0;
      cnt_q   <= LOAD;
    end else if (!active_i) begin
      armed_q <= 1'b0;
      cnt_q   <= LOAD;
    end else if (bus_i) begin
      armed_q <= 1'b1;
      cnt_q   <= LOAD;
    end else if (armed_q && cnt_q > ONE) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign wake_o = active_i && armed_q && !bus_i && (cnt_q == ONE);

  AST_FILT_DISARMED: assert property (@(posedge clk) disable iff (!por_n)
    !active_i |=> !wake_o); // R6

  generate
    if (DOM_TICKS > 1) begin : g_multi
      AST_FILT_NO_SHORT: assert property (@(posedge clk) disable iff (!por_n)
        (active_i && bus_i) |=> !wake_o); // R6
    end
  endgenerate
endmodule

// File: rtl/lin_txd_guard.sv
// Dominant time-out on the transmit line; the cut-off stays latched
// until TXD is sampled recessive.
module lin_txd_guard #(
  parameter int TO_TICKS = 8000
) (
  input  logic clk,
  input  logic por_n,
  input  logic txd_i,
  output logic timeout_o
);
  localparam int CW = $clog2(TO_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TO_TICKS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          to_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= LOAD;
      to_q  <= 1'b0;
    end else if (txd_i) begin
      cnt_q <= LOAD;
      to_q  <= 1'b0;
    end else begin
      if (cnt_q > ONE) cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) to_q <= 1'b1;
    end
  end

  assign timeout_o = to_q;

  AST_TO_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (to_q && !txd_i) |=> to_q); // R9
  AST_TO_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    txd_i |=> !to_q); // R9
endmodule

// File: rtl/lin_sleep_window.sv
// Measures how long TXD has been dominant; ok_o marks a sleep request
// that falls within the allowed lead time.
module lin_sleep_window #(
  parameter int WIN_TICKS = 64
) (
  input  logic clk,
  input  logic por_n,
  input  logic txd_i,
  output logic ok_o
);
  localparam int CW = $clog2(WIN_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIN_TICKS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              cnt_q <= LOAD;
    else if (txd_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign ok_o = !txd_i && (cnt_q != '0);

  AST_WIN_EXPIRED: assert property (@(posedge clk) disable iff (!por_n)
    (!txd_i && cnt_q == '0) |=> !ok_o); // R3
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mc_pkg::*;
#(
  parameter int HOLD_TICKS      = 4000,
  parameter int SLEEP_WIN_TICKS = 64,
  parameter int WAKE_DOM_TICKS  = 1200,
  parameter int TXD_TO_TICKS    = 8000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       bus_i,
  input  logic       wake_n_i,
  output logic [1:0] mode_o,
  output logic       reg_on_o,
  output logic       reg_lowtol_o,
  output logic       term_en_o,
  output logic       tx_en_o,
  output logic       bus_drv_o,
  output logic       rxd_o,
  output logic       nres_o
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_TICKS);
  localparam logic [HW-1:0] HONE      = HW'(1);

  lin_mode_e     mode_q, mode_d;
  logic          en_q, wake_n_q, flag_q;
  logic [HW-1:0] hold_q;
  logic          en_fall, loc_wake, bus_wake, any_wake, low_pwr;
  logic          sleep_ok, txd_to;

  assign low_pwr  = (mode_q == MODE_SILENT) || (mode_q == MODE_SLEEP);
  assign en_fall  = en_q && !en_i;
  assign loc_wake = low_pwr && wake_n_q && !wake_n_i;
  assign any_wake = loc_wake || bus_wake;

  lin_wake_filter #(.DOM_TICKS(WAKE_DOM_TICKS)) u_filt (
    .clk(clk), .por_n(por_n), .active_i(low_pwr), .bus_i(bus_i), .wake_o(bus_wake)
  );

  lin_sleep_window #(.WIN_TICKS(SLEEP_WIN_TICKS)) u_win (
    .clk(clk), .por_n(por_n), .txd_i(txd_i), .ok_o(sleep_ok)
  );

  lin_txd_guard #(.TO_TICKS(TXD_TO_TICKS)) u_guard (
    .clk(clk), .por_n(por_n), .txd_i(txd_i), .timeout_o(txd_to)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_PRE:    if (en_i) mode_d = MODE_NORM;
      MODE_NORM:   if (en_fall) mode_d = sleep_ok ? MODE_SLEEP : MODE_SILENT;
      MODE_SILENT: begin
        if (en_i)          mode_d = MODE_NORM;
        else if (any_wake) mode_d = MODE_PRE;
      end
      MODE_SLEEP:  if (any_wake) mode_d = MODE_PRE;
      default:     mode_d = MODE_PRE;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q   <= MODE_PRE;
      en_q     <= 1'b0;
      wake_n_q <= 1'b1;
      flag_q   <= 1'b0;
      hold_q   <= HOLD_LOAD;
    end else begin
      mode_q   <= mode_d;
      en_q     <= en_i;
      wake_n_q <= wake_n_i;
      if (mode_d == MODE_NORM)
        flag_q <= 1'b0;
      else if (low_pwr && mode_d == MODE_PRE)
        flag_q <= 1'b1;
      if (mode_q == MODE_SLEEP && mode_d == MODE_PRE)
        hold_q <= HOLD_LOAD;
      else if (mode_q != MODE_SLEEP && hold_q != '0)
        hold_q <= hold_q - HONE;
    end
  end

  assign mode_o       = mode_q;
  assign reg_on_o     = (mode_q != MODE_SLEEP);
  assign reg_lowtol_o = (mode_q == MODE_SILENT);
  assign term_en_o    = (mode_q == MODE_PRE) || (mode_q == MODE_NORM);
  assign tx_en_o      = (mode_q == MODE_NORM) && !txd_to;
  assign bus_drv_o    = tx_en_o ? txd_i : 1'b1;
  assign rxd_o        = flag_q ? 1'b0 : ((mode_q == MODE_SLEEP) ? 1'b1 : bus_i);
  assign nres_o       = (mode_q != MODE_SLEEP) && (hold_q == '0);

  AST_SLEEP_FROM_NORMAL: assert property (@(posedge clk) disable iff (!por_n)
    (mode_q != MODE_NORM && mode_q != MODE_SLEEP) |=> mode_q != MODE_SLEEP); // R3
  AST_SILENT_TO_NORMAL: assert property (@(posedge clk) disable iff (!por_n)
    (mode_q == MODE_SILENT && en_i) |=> mode_q == MODE_NORM); // R5
  AST_WAKE_IND_HELD: assert property (@(posedge clk) disable iff (!por_n)
    (flag_q && !en_i) |=> !rxd_o); // R8
  AST_NORMAL_STAYS: assert property (@(posedge clk) disable iff (!por_n)
    (mode_q == MODE_NORM && !en_fall) |=> mode_q == MODE_NORM); // R10
endmodule

// File: tb/tb_lin_mode_ctrl.sv
`timescale 1ns/1ps
module tb_lin_mode_ctrl;
  localparam int HOLD = 6;
  localparam int WIN  = 4;
  localparam int DOM  = 5;
  localparam int TO   = 10;
  localparam int M_PRE = 0, M_NORM = 1, M_SIL = 2, M_SLP = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0, en = 1'b0, txd = 1'b1, bus = 1'b1, wake_n = 1'b1;
  logic [1:0] mode;
  logic reg_on, reg_lt, term_en, tx_en, bus_drv, rxd, nres;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lin_mode_ctrl #(.HOLD_TICKS(HOLD), .SLEEP_WIN_TICKS(WIN),
                  .WAKE_DOM_TICKS(DOM), .TXD_TO_TICKS(TO)) dut (
    .clk(clk), .por_n(por_n), .en_i(en), .txd_i(txd), .bus_i(bus),
    .wake_n_i(wake_n), .mode_o(mode), .reg_on_o(reg_on), .reg_lowtol_o(reg_lt),
    .term_en_o(term_en), .tx_en_o(tx_en), .bus_drv_o(bus_drv), .rxd_o(rxd),
    .nres_o(nres)
  );

  function automatic int exp_after_enfall(input int k);
    return (k <= WIN) ? M_SLP : M_SIL;
  endfunction
  function automatic int exp_after_pulse(input int n);
    return (n >= DOM) ? M_PRE : M_SIL;
  endfunction
  function automatic int exp_txen(input int n);
    return (n >= TO) ? 0 : 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic to_normal();
    en = 1'b1; wake_n = 1'b1; step(1);
  endtask

  task automatic to_silent();
    txd = 1'b1; en = 1'b0; step(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_11a7));
    step(3);
    chk("R1 mode in reset", mode, M_PRE);
    chk("R1 nres in reset", nres, 0);
    por_n = 1'b1;
    step(HOLD - 1);
    chk("R1 nres still held", nres, 0);
    step(1);
    chk("R1 nres released", nres, 1);

    // R2: enter Normal, driver follows TXD
    to_normal();
    chk("R2 normal", mode, M_NORM);
    chk("R2 tx_en", tx_en, 1);
    chk("R2 term", term_en, 1);
    txd = 1'b0; #1;
    chk("R2 bus_drv dominant", bus_drv, 0);
    txd = 1'b1; #1;
    chk("R2 bus_drv recessive", bus_drv, 1);

    // R10: wake activity ignored in Normal
    wake_n = 1'b0; bus = 1'b0; step(DOM + 2);
    chk("R10 normal kept", mode, M_NORM);
    wake_n = 1'b1; bus = 1'b1; step(1);

    // R9: TXD time-out
    txd = 1'b0; step(TO - 1);
    chk("R9 before time-out", tx_en, 1);
    step(1);
    chk("R9 time-out tx_en", tx_en, 0);
    chk("R9 time-out bus_drv", bus_drv, 1);
    step(3);
    chk("R9 still cut", tx_en, 0);
    txd = 1'b1; step(1);
    chk("R9 cleared", tx_en, 1);

    // R4: EN fall with TXD high
    to_silent();
    chk("R4 silent", mode, M_SIL);
    chk("R4 lowtol", reg_lt, 1);
    chk("R4 tx off", tx_en, 0);
    chk("R4 term off", term_en, 0);
    bus = 1'b0; #1;
    chk("R4 rxd follows bus", rxd, 0);
    bus = 1'b1; #1;

    // R5
    to_normal();
    chk("R5 silent to normal", mode, M_NORM);

    // R3: lead of exactly WIN samples
    txd = 1'b0; step(WIN - 1); en = 1'b0; step(1);
    chk("R3 sleep at window edge", mode, M_SLP);
    chk("R3 regulator off", reg_on, 0);
    chk("R3 nres low", nres, 0);
    txd = 1'b1; step(2);

    // R6: short pulse ignored in Sleep, full one wakes
    bus = 1'b0; step(DOM - 1); bus = 1'b1; step(1);
    chk("R6 short pulse ignored", mode, M_SLP);
    bus = 1'b0; step(DOM);
    chk("R6 remote wake", mode, M_PRE);
    bus = 1'b1;
    chk("R8 rxd wake indication", rxd, 0);
    chk("R8 nres low after sleep", nres, 0);
    step(HOLD - 1);
    chk("R8 hold restarted", nres, 0);
    step(1);
    chk("R8 hold released", nres, 1);
    chk("R8 rxd still low", rxd, 0);
    to_normal();
    chk("R8 rxd released", rxd, 1);

    // R4 boundary: one sample past the window
    txd = 1'b0; step(WIN); en = 1'b0; step(1);
    chk("R4 past window", mode, M_SIL);
    txd = 1'b1; to_normal();

    // R6: bus dominant from Silent entry does not wake
    bus = 1'b0; txd = 1'b1; en = 1'b0; step(1);
    chk("R6 silent entered", mode, M_SIL);
    step(DOM + 2);
    chk("R6 stuck bus ignored", mode, M_SIL);
    bus = 1'b1; step(1);
    bus = 1'b0; step(DOM);
    chk("R6 wake from silent", mode, M_PRE);
    chk("R8 nres kept after silent wake", nres, 1);
    bus = 1'b1; #1;
    chk("R8 rxd low from silent wake", rxd, 0);
    to_normal();

    // R7: local wake from Silent and Sleep
    to_silent();
    wake_n = 1'b0; step(1);
    chk("R7 local wake silent", mode, M_PRE);
    to_normal();
    txd = 1'b0; en = 1'b0; step(1);
    chk("R3 sleep single sample", mode, M_SLP);
    txd = 1'b1; step(2);
    wake_n = 1'b0; step(1);
    chk("R7 local wake sleep", mode, M_PRE);
    to_normal();

    // random mix
    for (int it = 0; it < 60; it++) begin
      int sel = $urandom % 3;
      if (sel == 0) begin
        int k = 1 + ($urandom % (WIN + 3));
        txd = 1'b0; step(k - 1); en = 1'b0; step(1);
        chk("R3 random sleep window", mode, exp_after_enfall(k));
        txd = 1'b1;
        if (mode == 2'(M_SLP)) begin wake_n = 1'b0; step(1); end
        to_normal();
      end else if (sel == 1) begin
        int n = 1 + ($urandom % (DOM + 3));
        to_silent(); step(2);
        bus = 1'b0; step(n);
        chk("R6 random dominant pulse", mode, exp_after_pulse(n));
        bus = 1'b1;
        to_normal();
      end else begin
        int n = 1 + ($urandom % (TO + 4));
        txd = 1'b0; step(n);
        chk("R9 random TXD low", tx_en, exp_txen(n));
        txd = 1'b1; step(1);
      end
      chk("R2 back in normal", mode, M_NORM);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule